// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Side Buffer

This block is a direct-mapped cache for a 24-bit byte address. A small fully associative side buffer sits beside the main array and holds lines that the main array has recently pushed out. A CPU request that misses the main array is searched against the side buffer in the next cycle. On a side-buffer hit, the two lines trade places and the request completes without any memory traffic. The next memory level is used only when both structures miss. Conflicting blocks that share one index can therefore alternate without refetching.

The CPU keeps `cpu_req` and its request fields stable until `cpu_done` pulses. A read returns the whole line. A write merges the strobed bytes into the line and marks it dirty. On the memory side, a read port fetches one block by its block address. A write port sends a dirty line back only when that line leaves the side buffer. Each port holds its request until the memory answers.

Top module: `dmvc_cache`

## Requirements
- R1: The address splits into an upper tag, an IDX_W-bit line index (14 for the full 16K-line configuration) and a low 2-bit byte field. A hit needs the stored tag to equal the address tag. A read returns the whole 4-byte line whatever the byte field holds.
- R2: A request that hits the main array raises `cpu_done` in the same cycle it is presented and causes no memory request.
- R3: A main miss that hits the side buffer completes in the second cycle with no memory request. The requested line moves into its main slot, and the displaced main line takes the freed buffer entry.
- R4: A miss in both structures raises `mem_rd_req` with the 22-bit block address. The cycle after `mem_rd_valid`, the request completes with the fetched line.
- R5: A valid line displaced from the main array by a fill goes into the side buffer and is not discarded. A later access to it is a side-buffer hit.
- R6: Fill insertions into the side buffer go to a round-robin slot. When that slot already holds a line, the oldest inserted line is the one that leaves.
- R7: A write sets the line's dirty flag, and the flag travels with the line through swaps. A line is sent to memory only if it is dirty when it leaves the side buffer. Clean lines leave silently.
- R8: A dirty write-back completes (request held with stable address until `mem_wr_ack`) before the fill starts. The read and write ports are never active together.
- R9: A block is never resident in the main array and the side buffer at the same time. At most one buffer entry matches.
- R10: After reset no line is valid, no memory request is active and the first access misses.
- R11: Alternating accesses to two blocks with the same index cause exactly two memory fetches, however long the alternation runs.
- R12: A write changes only the bytes whose `cpu_be` bit is 1 (bit b selects bits 8b+7..8b). All other bytes keep their old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_be | input | LINE_B | Byte strobes for writes |
| cpu_wdata | input | LINE_W | Write data, line-wide |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_rdata | output | LINE_W | Line contents, valid with `cpu_done` |
| mem_rd_req | output | 1 | Block fetch request |
| mem_rd_addr | output | BLK_W | Block address to fetch |
| mem_rd_valid | input | 1 | Fetched block is on `mem_rd_data` |
| mem_rd_data | input | LINE_W | Fetched block |
| mem_wr_req | output | 1 | Write-back request |
| mem_wr_addr | output | BLK_W | Block address written back |
| mem_wr_data | output | LINE_W | Line written back |
| mem_wr_ack | input | 1 | Write-back accepted |

## Verification
Several rules are checked on every cycle: at most one side-buffer entry matches, and a main hit never coincides with a buffer hit. A completing request never overlaps memory traffic, and the two memory ports never overlap. A held write-back keeps its address, and a write-back or fill is always followed by the expected next step. The bench's scenarios are needed to show the rest. Those are the two-cycle swap timing, the FIFO choice of which line leaves, byte-strobe merging, the data a dirty line carries back to memory, and the fact that a thrashing pair stops fetching after two misses.

// File: rtl/dmvc_pkg.sv
package dmvc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_PROBE  = 2'd1,
      ST_EVICT  = 2'd2,
      ST_REFILL = 2'd3
   } dmvc_state_e;
endpackage

// File: rtl/dmvc_main_array.sv
module dmvc_main_array #(
   parameter int IDX_W  = 6,
   parameter int TAG_W  = 16,
   parameter int LINE_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic              rd_dirty,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [LINE_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic              wr_dirty,
   input  logic [LINE_W-1:0] wr_data
);
   localparam int LINES = 1 << IDX_W;

   logic [LINES-1:0]  vld_q;
   logic [LINES-1:0]  drt_q;
   logic [TAG_W-1:0]  tag_q  [LINES];
   logic [LINE_W-1:0] data_q [LINES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         drt_q <= '0;
      end else if (wr_en) begin
         vld_q[wr_idx] <= 1'b1;
         drt_q[wr_idx] <= wr_dirty;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx]  <= wr_tag;
         data_q[wr_idx] <= wr_data;
      end
   end

   assign rd_valid = vld_q[rd_idx];
   assign rd_dirty = drt_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];
   assign rd_data  = data_q[rd_idx];
endmodule

// File: rtl/dmvc_victim_buf.sv
module dmvc_victim_buf #(
   parameter int VB_N       = 4,
   parameter int BLK_W      = 22,
   parameter int LINE_W     = 32,
   parameter bit PICK_ONEHOT = 1'b1,
   localparam int PTR_W     = (VB_N > 1) ? $clog2(VB_N) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BLK_W-1:0]  look_blk,
   output logic [VB_N-1:0]   hit_vec,
   output logic              hit,
   output logic [PTR_W-1:0]  hit_slot,
   output logic              hit_dirty,
   output logic [LINE_W-1:0] hit_data,
   output logic [PTR_W-1:0]  ptr,
   output logic              ptr_valid,
   output logic              ptr_dirty,
   output logic [BLK_W-1:0]  ptr_blk,
   output logic [LINE_W-1:0] ptr_data,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_slot,
   input  logic              wr_valid,
   input  logic [BLK_W-1:0]  wr_blk,
   input  logic              wr_dirty,
   input  logic [LINE_W-1:0] wr_data,
   input  logic              adv
);
   logic [VB_N-1:0]   vld_q;
   logic [VB_N-1:0]   drt_q;
   logic [BLK_W-1:0]  blk_q  [VB_N];
   logic [LINE_W-1:0] data_q [VB_N];
   logic [PTR_W-1:0]  ptr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         drt_q <= '0;
         ptr_q <= '0;
      end else begin
         if (wr_en) begin
            vld_q[wr_slot] <= wr_valid;
            drt_q[wr_slot] <= wr_dirty;
         end
         if (adv)
            ptr_q <= (ptr_q == PTR_W'(VB_N - 1)) ? '0 : ptr_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         blk_q[wr_slot]  <= wr_blk;
         data_q[wr_slot] <= wr_data;
      end
   end

   for (genvar g = 0; g < VB_N; g++) begin : g_cmp
      assign hit_vec[g] = vld_q[g] && (blk_q[g] == look_blk);
   end

   assign hit = |hit_vec;

   if (PICK_ONEHOT) begin : g_pick_or
      always_comb begin
         hit_slot  = '0;
         hit_dirty = 1'b0;
         hit_data  = '0;
         for (int i = 0; i < VB_N; i++) begin
            hit_slot  = hit_slot  | ({PTR_W{hit_vec[i]}} & PTR_W'(i));
            hit_dirty = hit_dirty | (hit_vec[i] & drt_q[i]);
            hit_data  = hit_data  | ({LINE_W{hit_vec[i]}} & data_q[i]);
         end
      end
   end else begin : g_pick_pri
      always_comb begin
         hit_slot  = '0;
         hit_dirty = 1'b0;
         hit_data  = '0;
         for (int i = VB_N - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
               hit_slot  = PTR_W'(i);
               hit_dirty = drt_q[i];
               hit_data  = data_q[i];
            end
         end
      end
   end

   assign ptr       = ptr_q;
   assign ptr_valid = vld_q[ptr_q];
   assign ptr_dirty = drt_q[ptr_q];
   assign ptr_blk   = blk_q[ptr_q];
   assign ptr_data  = data_q[ptr_q];
endmodule

// File: rtl/dmvc_ctrl.sv
module dmvc_ctrl
   import dmvc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_req,
   input  logic main_hit,
   input  logic main_valid,
   input  logic vb_hit,
   input  logic ptr_valid,
   input  logic ptr_dirty,
   input  logic mem_rd_valid,
   input  logic mem_wr_ack,
   output logic hit_done,
   output logic swap_done,
   output logic fill_commit,
   output logic mem_rd_req,
   output logic mem_wr_req
);
   dmvc_state_e st_q, st_d;

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   always_comb begin
      st_d        = st_q;
      hit_done    = 1'b0;
      swap_done   = 1'b0;
      fill_commit = 1'b0;
      mem_rd_req  = 1'b0;
      mem_wr_req  = 1'b0;
      case (st_q)
         ST_IDLE: begin
            hit_done = cpu_req && main_hit;
            if (cpu_req && !main_hit) st_d = ST_PROBE;
         end
         ST_PROBE: begin
            if (vb_hit) begin
               swap_done = 1'b1;
               st_d      = ST_IDLE;
            end else if (main_valid && ptr_valid && ptr_dirty) begin
               st_d = ST_EVICT;
            end else begin
               st_d = ST_REFILL;
            end
         end
         ST_EVICT: begin
            mem_wr_req = 1'b1;
            if (mem_wr_ack) st_d = ST_REFILL;
         end
         ST_REFILL: begin
            mem_rd_req = 1'b1;
            if (mem_rd_valid) begin
               fill_commit = 1'b1;
               st_d        = ST_IDLE;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end
endmodule

// File: rtl/dmvc_cache.sv
module dmvc_cache #(
   parameter int ADDR_W      = 24,
   parameter int OFF_W       = 2,
   parameter int IDX_W       = 6,
   parameter int VB_N        = 4,
   parameter bit PICK_ONEHOT = 1'b1,
   localparam int LINE_B     = 1 << OFF_W,
   localparam int LINE_W     = 8 * LINE_B,
   localparam int BLK_W      = ADDR_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [LINE_B-1:0] cpu_be,
   input  logic [LINE_W-1:0] cpu_wdata,
   output logic              cpu_done,
   output logic [LINE_W-1:0] cpu_rdata,
   output logic              mem_rd_req,
   output logic [BLK_W-1:0]  mem_rd_addr,
   input  logic              mem_rd_valid,
   input  logic [LINE_W-1:0] mem_rd_data,
   output logic              mem_wr_req,
   output logic [BLK_W-1:0]  mem_wr_addr,
   output logic [LINE_W-1:0] mem_wr_data,
   input  logic              mem_wr_ack
);
   localparam int TAG_W = BLK_W - IDX_W;
   localparam int PTR_W = (VB_N > 1) ? $clog2(VB_N) : 1;

   if (VB_N < 4 || VB_N > 16) begin : g_bad_vb
      $error("dmvc_cache: VB_N must lie in 4..16");
   end
   if (IDX_W < 1 || IDX_W >= BLK_W) begin : g_bad_idx
      $error("dmvc_cache: IDX_W must leave at least one tag bit");
   end

   logic [BLK_W-1:0]  cur_blk;
   logic [IDX_W-1:0]  cur_idx;
   logic [TAG_W-1:0]  cur_tag;
   assign cur_blk = cpu_addr[ADDR_W-1:OFF_W];
   assign cur_idx = cur_blk[IDX_W-1:0];
   assign cur_tag = cur_blk[BLK_W-1:IDX_W];

   logic              main_valid, main_dirty, main_hit;
   logic [TAG_W-1:0]  main_tag;
   logic [LINE_W-1:0] main_data;
   logic              m_wr_en, m_wr_dirty;
   logic [LINE_W-1:0] m_wr_data;

   logic [VB_N-1:0]   vb_hit_vec;
   logic              vb_hit, vb_hit_dirty, ptr_valid, ptr_dirty;
   logic [PTR_W-1:0]  vb_hit_slot, vb_ptr;
   logic [LINE_W-1:0] vb_hit_data, ptr_data;
   logic [BLK_W-1:0]  ptr_blk;
   logic              v_wr_en, v_adv;
   logic [PTR_W-1:0]  v_wr_slot;

   logic              hit_done, swap_done, fill_commit;
   logic [LINE_W-1:0] base_line, merged_line;

   dmvc_main_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_main (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (cur_idx),
      .rd_valid (main_valid),
      .rd_dirty (main_dirty),
      .rd_tag   (main_tag),
      .rd_data  (main_data),
      .wr_en    (m_wr_en),
      .wr_idx   (cur_idx),
      .wr_tag   (cur_tag),
      .wr_dirty (m_wr_dirty),
      .wr_data  (m_wr_data)
   );

   assign main_hit = main_valid && (main_tag == cur_tag);

   dmvc_victim_buf #(.VB_N(VB_N), .BLK_W(BLK_W), .LINE_W(LINE_W),
                     .PICK_ONEHOT(PICK_ONEHOT)) u_vb (
      .clk       (clk),
      .rst_n     (rst_n),
      .look_blk  (cur_blk),
      .hit_vec   (vb_hit_vec),
      .hit       (vb_hit),
      .hit_slot  (vb_hit_slot),
      .hit_dirty (vb_hit_dirty),
      .hit_data  (vb_hit_data),
      .ptr       (vb_ptr),
      .ptr_valid (ptr_valid),
      .ptr_dirty (ptr_dirty),
      .ptr_blk   (ptr_blk),
      .ptr_data  (ptr_data),
      .wr_en     (v_wr_en),
      .wr_slot   (v_wr_slot),
      .wr_valid  (main_valid),
      .wr_blk    ({main_tag, cur_idx}),
      .wr_dirty  (main_dirty),
      .wr_data   (main_data),
      .adv       (v_adv)
   );

   dmvc_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .cpu_req      (cpu_req),
      .main_hit     (main_hit),
      .main_valid   (main_valid),
      .vb_hit       (vb_hit),
      .ptr_valid    (ptr_valid),
      .ptr_dirty    (ptr_dirty),
      .mem_rd_valid (mem_rd_valid),
      .mem_wr_ack   (mem_wr_ack),
      .hit_done     (hit_done),
      .swap_done    (swap_done),
      .fill_commit  (fill_commit),
      .mem_rd_req   (mem_rd_req),
      .mem_wr_req   (mem_wr_req)
   );

   // byte-lane merge of write data into the line being completed
   assign base_line = swap_done ? vb_hit_data : main_data;
   for (genvar b = 0; b < LINE_B; b++) begin : g_lane
      assign merged_line[8*b +: 8] = cpu_be[b] ? cpu_wdata[8*b +: 8] : base_line[8*b +: 8];
   end

   assign m_wr_en    = (hit_done && cpu_we) || swap_done || fill_commit;
   assign m_wr_data  = fill_commit ? mem_rd_data : (cpu_we ? merged_line : vb_hit_data);
   assign m_wr_dirty = fill_commit ? 1'b0 : (swap_done ? (vb_hit_dirty || cpu_we) : 1'b1);

   assign v_adv     = fill_commit && main_valid;
   assign v_wr_en   = swap_done || v_adv;
   assign v_wr_slot = swap_done ? vb_hit_slot : vb_ptr;

   assign cpu_done    = hit_done || swap_done;
   assign cpu_rdata   = base_line;
   assign mem_rd_addr = cur_blk;
   assign mem_wr_addr = ptr_blk;
   assign mem_wr_data = ptr_data;
endmodule

// File: rtl/dmvc_cache_chk.sv
module dmvc_cache_chk #(
   parameter int BLK_W = 22,
   parameter int VB_N  = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cpu_req,
   input logic             cpu_done,
   input logic             main_hit,
   input logic             vb_hit,
   input logic [VB_N-1:0]  vb_hit_vec,
   input logic             mem_rd_req,
   input logic             mem_rd_valid,
   input logic             mem_wr_req,
   input logic             mem_wr_ack,
   input logic [BLK_W-1:0] mem_wr_addr
);
   AST_VB_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(vb_hit_vec)); // R9
   AST_NO_DUAL_HOME: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && main_hit) |-> !vb_hit); // R9
   AST_DONE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |-> cpu_req); // R2
   AST_DONE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |-> (!mem_rd_req && !mem_wr_req)); // R3
   AST_PORTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_req && mem_wr_req)); // R8
   AST_WB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(mem_wr_addr))); // R8
   AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_req && mem_wr_ack) |=> mem_rd_req); // R8
   AST_FILL_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && mem_rd_valid && cpu_req) |=> cpu_done); // R4
endmodule

bind dmvc_cache dmvc_cache_chk #(.BLK_W(BLK_W), .VB_N(VB_N)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cpu_req      (cpu_req),
   .cpu_done     (cpu_done),
   .main_hit     (main_hit),
   .vb_hit       (vb_hit),
   .vb_hit_vec   (vb_hit_vec),
   .mem_rd_req   (mem_rd_req),
   .mem_rd_valid (mem_rd_valid),
   .mem_wr_req   (mem_wr_req),
   .mem_wr_ack   (mem_wr_ack),
   .mem_wr_addr  (mem_wr_addr)
);

// File: tb/dmvc_cache_bench.sv
`timescale 1ns/1ps
module dmvc_cache_bench;
   localparam int IDX_W = 6;
   localparam int VB_N  = 4;
   localparam int LINES = 1 << IDX_W;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [23:0] cpu_addr = '0;
   logic [3:0]  cpu_be = '0;
   logic [31:0] cpu_wdata = '0;
   logic        cpu_done;
   logic [31:0] cpu_rdata;
   logic        mem_rd_req, mem_wr_req;
   logic [21:0] mem_rd_addr, mem_wr_addr;
   logic        mem_rd_valid = 1'b0, mem_wr_ack = 1'b0;
   logic [31:0] mem_rd_data = '0, mem_wr_data;

   always #4 clk = ~clk;

   dmvc_cache #(.IDX_W(IDX_W), .VB_N(VB_N)) u_dmvc_cache (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
      .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
      .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
      .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack)
   );

   int checks = 0, errors = 0;
   int fills = 0, wbs = 0;
   int exp_fills = 0, exp_wbs = 0;
   int exp_cls = 0;
   bit in_acc = 0;
   bit done_flag = 0;

   // memory seen by the design, and the model's view of memory
   logic [31:0] dut_mem [int];
   logic [31:0] ref_mem [int];

   function automatic logic [31:0] pat(int b);
      return (32'(b) * 32'h0100_0193) ^ 32'hA5C3_0000;
   endfunction

   // behavioural model state
   bit          m_v [LINES];
   int          m_t [LINES];
   bit          m_d [LINES];
   logic [31:0] m_x [LINES];
   bit          v_v [VB_N];
   int          v_b [VB_N];
   bit          v_d [VB_N];
   logic [31:0] v_x [VB_N];
   int          v_p = 0;

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] wd, logic [3:0] be);
      logic [31:0] r = old;
      for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = wd[8*b +: 8];
      return r;
   endfunction

   // memory responder: reads answer on the second request cycle, writes on the first
   int rd_cnt = 0;
   always @(negedge clk) begin
      mem_rd_valid = 1'b0;
      mem_wr_ack   = 1'b0;
      if (mem_wr_req) begin
         dut_mem[int'(mem_wr_addr)] = mem_wr_data;
         mem_wr_ack = 1'b1;
         wbs++;
      end else if (mem_rd_req) begin
         rd_cnt++;
         if (rd_cnt == 2) begin
            rd_cnt = 0;
            mem_rd_data  = dut_mem.exists(int'(mem_rd_addr)) ? dut_mem[int'(mem_rd_addr)] : pat(int'(mem_rd_addr));
            mem_rd_valid = 1'b1;
            fills++;
         end
      end
      if (in_acc) begin
         if (mem_rd_req && exp_cls != 2) begin
            checks++; errors++;
            $display("FAIL R3: got mem_rd_req 1 expected 0 on non-miss access");
         end
         if (mem_rd_req && mem_wr_req) begin
            checks++; errors++;
            $display("FAIL R8: got both memory ports 1 expected 0");
         end
      end
   end

   function automatic logic [23:0] mk(int tg, int idx);
      return 24'((tg << (IDX_W + 2)) | (idx << 2));
   endfunction

   // model one access; returns expected class and read data
   task automatic predict(bit we, logic [23:0] a, logic [31:0] wd, logic [3:0] be,
                          output int cls, output logic [31:0] rd);
      int blk = int'(a >> 2);
      int idx = blk & (LINES - 1);
      int tg  = blk >> IDX_W;
      int j   = -1;
      if (m_v[idx] && m_t[idx] == tg) begin
         cls = 0;
         rd  = m_x[idx];
         if (we) begin m_x[idx] = merge(m_x[idx], wd, be); m_d[idx] = 1; end
         return;
      end
      for (int k = 0; k < VB_N; k++) if (v_v[k] && v_b[k] == blk) j = k;
      if (j >= 0) begin
         bit ov = m_v[idx]; int ob = (m_t[idx] << IDX_W) | idx; bit od = m_d[idx]; logic [31:0] ox = m_x[idx];
         cls = 1;
         rd  = v_x[j];
         m_v[idx] = 1; m_t[idx] = tg; m_d[idx] = v_d[j] | we;
         m_x[idx] = we ? merge(v_x[j], wd, be) : v_x[j];
         v_v[j] = ov; v_b[j] = ob; v_d[j] = od; v_x[j] = ox;
         return;
      end
      cls = 2;
      exp_fills++;
      if (m_v[idx]) begin
         if (v_v[v_p] && v_d[v_p]) begin
            exp_wbs++;
            ref_mem[v_b[v_p]] = v_x[v_p];
         end
         v_v[v_p] = 1; v_b[v_p] = (m_t[idx] << IDX_W) | idx; v_d[v_p] = m_d[idx]; v_x[v_p] = m_x[idx];
         v_p = (v_p + 1) % VB_N;
      end
      m_v[idx] = 1; m_t[idx] = tg; m_d[idx] = 0;
      m_x[idx] = ref_mem.exists(blk) ? ref_mem[blk] : pat(blk);
      rd = m_x[idx];
      if (we) begin m_x[idx] = merge(m_x[idx], wd, be); m_d[idx] = 1; end
   endtask

   int last_cls;
   task automatic acc(bit we, logic [23:0] a, logic [31:0] wd, logic [3:0] be, string req);
      int cls, cyc = 0, got_cls;
      logic [31:0] erd, grd;
      bit seen = 0;
      predict(we, a, wd, be, cls, erd);
      exp_cls = cls;
      @(negedge clk);
      cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
      in_acc = 1;
      while (!seen && cyc < 100) begin
         cyc++;
         #1;
         if (cpu_done) begin seen = 1; grd = cpu_rdata; end
         else @(negedge clk);
      end
      @(negedge clk);
      cpu_req = 0; cpu_we = 0;
      in_acc = 0;
      got_cls = (cyc == 1) ? 0 : (cyc == 2) ? 1 : 2;
      last_cls = got_cls;
      check({req, " latency class"}, 32'(got_cls), 32'(cls));
      if (!we) check({req, " read data"}, grd, erd);
      check({req, " R4 fetch count"}, 32'(fills), 32'(exp_fills));
      check({req, " R7 write-back count"}, 32'(wbs), 32'(exp_wbs));
   endtask

   initial begin
      #(8 * 150000);
      if (!done_flag) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [23:0] a_blk, b_blk;
      int f0;
      logic [15:0] lf = 16'hACE1;
      repeat (3) @(negedge clk);
      // R10: reset state at the ports
      check("R10 cpu_done after reset", 32'(cpu_done), 0);
      check("R10 mem_rd_req after reset", 32'(mem_rd_req), 0);
      check("R10 mem_wr_req after reset", 32'(mem_wr_req), 0);
      rst_n = 1;

      a_blk = mk(1, 5);
      b_blk = mk(2, 5);
      acc(0, a_blk, 0, 0, "R10 first access");
      check("R10 first access misses", 32'(last_cls), 2);
      acc(0, a_blk, 0, 0, "R2 repeat hit");
      acc(0, a_blk | 24'd3, 0, 0, "R1 byte field ignored");
      acc(0, mk(1 | 16'h8000, 5), 0, 0, "R1 tag top bit differs");
      acc(0, a_blk, 0, 0, "R5 return after displacement");
      acc(1, a_blk, 32'hDEAD_BEEF, 4'b0101, "R12 strobed write");
      acc(0, a_blk, 0, 0, "R12 readback");

      // R11: thrash pair on one index; only the first two touches fetch
      acc(0, b_blk, 0, 0, "R11 pair second block");
      f0 = fills;
      for (int i = 0; i < 12; i++) begin
         acc(i[0], i[0] ? a_blk : b_blk, 32'h1111_0000 + 32'(i), 4'b1000, "R3 swap");
      end
      check("R11 no fetch during alternation", 32'(fills), 32'(f0));

      // R6/R7: push lines through the buffer so dirty ones leave in FIFO order
      for (int k = 0; k < VB_N + 3; k++) begin
         acc(1, mk(3, 10 + k), 32'h5500_0000 + 32'(k), 4'b1111, "R7 dirty fill");
         acc(0, mk(4, 10 + k), 0, 0, "R6 push to buffer");
      end
      check("R7 dirty lines were written back", 32'(wbs > 0), 1);
      acc(0, mk(3, 10), 0, 0, "R6 oldest left buffer");
      acc(0, mk(3, 10 + VB_N + 2), 0, 0, "R6 newest still buffered");
      check("R6 newest is victim hit", 32'(last_cls), 1);
      acc(0, a_blk, 0, 0, "R7 dirty data returns");

      // mixed traffic over a few colliding indices
      for (int n = 0; n < 400; n++) begin
         int tg, ix;
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         tg = 1 + int'(lf[1:0]) + (lf[9] ? 4 : 0);
         ix = (lf[3:2] == 2'd0) ? 3 : (lf[3:2] == 2'd1) ? 4 : 40;
         acc(lf[4], mk(tg, ix) | 24'(lf[6:5]), {lf, ~lf}, lf[11:8], "R9 mixed traffic");
      end

      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule